// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a synthesizable model of a single-port static memory whose inputs are all registered on the rising clock edge. An address is taken in on either of two active-low address strobes. The processor-side strobe outranks the controller-side strobe. The two low address bits seed a two-bit burst counter. An active-low advance input then walks the counter through a four-beat burst. A static order input chooses whether the burst steps through the low bits in linear or interleaved order.

Each data lane is one byte wide and carries its own parity bit, which is stored and returned with it. The bidirectional bus is split into write ports, read ports and a read-valid flag. Read data is flow-through from the address register: after the edge that loads or steps an address, the outputs already show that location. An active-high sleep input freezes every register except the clock and releases the outputs, and the stored contents are kept.

Top module: `sync_burst_ram`

## Requirements
- R1: Reset clears the address register and the burst counter, so a write issued with no strobe straight after reset lands at address 0.
- R2: When either strobe is low at an edge, the full address is loaded and the beat count restarts at 0. From the next sample on, the outputs show the data at that address. A controller-strobe edge with write enable low writes the write-port data to the address presented on that edge.
- R3: When the processor strobe is low, the write enable is ignored on that edge, including when both strobes are low. Only the processor strobe's behaviour applies.
- R4: With the order input at 0 (linear), beat n reads low address bits (start + n) mod 4.
- R5: With the order input at 1 (interleaved), beat n reads low address bits start XOR n.
- R6: With no strobe and the advance input high, the burst address holds from edge to edge.
- R7: With no strobe and write enable low, the write-port data and parity are written at the current burst address. An advance on the same edge moves the address only after the write.
- R8: While sleep is high, strobes, writes and advances have no effect and the read-valid flag is low. After sleep drops, the address and the array are as they were before sleep.
- R9: While output enable is high, the read-valid flag is 0 and the read data and read parity are all zero.
- R10: Each byte lane returns the parity bit written with it. Parity bit i belongs to data bits [8i+7:8i].
- R11: On an edge where a strobe and the advance input are both low, the strobe wins and the beat count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| procStrobeN | input | 1 | Processor-side address strobe, active low, highest priority |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| writeEnN | input | 1 | Global write enable, active low |
| orderSel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| sleep | input | 1 | Active-high sleep, contents preserved |
| outEnN | input | 1 | Output enable, active low |
| addrIn | input | ADDR_W | Address |
| wrData | input | LANES*LANE_W | Write data |
| wrPar | input | LANES | Write parity, one bit per lane |
| rdData | output | LANES*LANE_W | Read data, zero when released |
| rdPar | output | LANES | Read parity, zero when released |
| rdValid | output | 1 | Outputs are driven |

## Verification
Every address and counter update takes effect on the edge that samples it. The outputs are flow-through from those registers, so read data for a load, a step or a write is due in the same cycle as that edge. The bench drives its inputs just after a rising edge and samples just after the next one, so each sample sees exactly one edge's effect. Release on output enable or sleep is combinational and is checked before any further edge.

// File: rtl/sync_burst_ram_pkg.sv
package sync_burst_ram_pkg;
  typedef struct packed {
    logic loadAddr;
    logic stepBeat;
    logic writeMem;
    logic driveOut;
  } ctl_strobe_t;
endpackage

// File: rtl/sync_burst_ram_ctrl.sv
module sync_burst_ram_ctrl
  import sync_burst_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        advanceN,
  input  logic        writeEnN,
  input  logic        orderSel,
  input  logic        sleep,
  input  logic        outEnN,
  input  logic [1:0]  startBits,
  output ctl_strobe_t ctlStrobe,
  output logic [1:0]  burstLow
);
  logic       anyStrobe;
  logic [1:0] baseReg;
  logic [1:0] beatReg;

  assign anyStrobe = !procStrobeN || !ctrlStrobeN;

  always_comb begin
    ctlStrobe.loadAddr = !sleep && anyStrobe;
    ctlStrobe.stepBeat = !sleep && !anyStrobe && !advanceN;
    // processor strobe suppresses the write on its edge
    ctlStrobe.writeMem = !sleep && procStrobeN && !writeEnN;
    ctlStrobe.driveOut = !sleep && !outEnN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseReg <= '0;
      beatReg <= '0;
    end else if (ctlStrobe.loadAddr) begin
      baseReg <= startBits;
      beatReg <= '0;
    end else if (ctlStrobe.stepBeat) begin
      beatReg <= beatReg + 2'd1;
    end
  end

  assign burstLow = orderSel ? (baseReg ^ beatReg) : (baseReg + beatReg);
endmodule

// File: rtl/sync_burst_ram_dp.sv
module sync_burst_ram_dp
  import sync_burst_ram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctl_strobe_t             ctlStrobe,
  input  logic [1:0]              burstLow,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        wrPar,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES-1:0]        rdPar,
  output logic                    rdValid,
  output logic [ADDR_W-1:0]       curAddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 2;

  logic [HI_W-1:0]   upperReg;
  logic [ADDR_W-1:0] writeAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) upperReg <= '0;
    else if (ctlStrobe.loadAddr) upperReg <= addrIn[ADDR_W-1:2];
  end

  assign curAddr   = {upperReg, burstLow};
  assign writeAddr = ctlStrobe.loadAddr ? addrIn : curAddr;
  assign rdValid   = ctlStrobe.driveOut;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W:0] laneMem [DEPTH];
    logic [LANE_W:0] laneWord;

    always_ff @(posedge clk) begin
      if (ctlStrobe.writeMem)
        laneMem[writeAddr] <= {wrPar[g], wrData[g*LANE_W +: LANE_W]};
    end

    assign laneWord = laneMem[curAddr];
    assign rdData[g*LANE_W +: LANE_W] = ctlStrobe.driveOut ? laneWord[LANE_W-1:0] : '0;
    assign rdPar[g] = ctlStrobe.driveOut ? laneWord[LANE_W] : 1'b0;
  end
endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
  import sync_burst_ram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advanceN,
  input  logic                    writeEnN,
  input  logic                    orderSel,
  input  logic                    sleep,
  input  logic                    outEnN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        wrPar,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES-1:0]        rdPar,
  output logic                    rdValid
);
  ctl_strobe_t       ctlStrobe;
  logic [1:0]        burstLow;
  logic [ADDR_W-1:0] curAddr;

  sync_burst_ram_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .writeEnN(writeEnN), .orderSel(orderSel), .sleep(sleep),
    .outEnN(outEnN), .startBits(addrIn[1:0]), .ctlStrobe(ctlStrobe), .burstLow(burstLow)
  );

  sync_burst_ram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctlStrobe(ctlStrobe), .burstLow(burstLow),
    .addrIn(addrIn), .wrData(wrData), .wrPar(wrPar), .rdData(rdData),
    .rdPar(rdPar), .rdValid(rdValid), .curAddr(curAddr)
  );
endmodule

// File: rtl/sync_burst_ram_chk.sv
module sync_burst_ram_chk
  import sync_burst_ram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DW     = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              sleep,
  input logic              outEnN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [DW-1:0]     rdData,
  input logic [LANES-1:0]  rdPar,
  input logic              rdValid,
  input logic [ADDR_W-1:0] curAddr,
  input ctl_strobe_t       ctlStrobe
);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> (!rdValid && rdData == '0 && rdPar == '0));

  p_sleep_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdValid);

  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(curAddr));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctrlStrobeN) |=> curAddr == $past(addrIn));

  p_proc_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !procStrobeN |-> !ctlStrobe.writeMem);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && procStrobeN && ctrlStrobeN && advanceN) |=> $stable(curAddr));

  p_strobe_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !procStrobeN && !advanceN) |=> curAddr == $past(addrIn));
endmodule

bind sync_burst_ram sync_burst_ram_chk #(.ADDR_W(ADDR_W), .DW(LANES*LANE_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
  .advanceN(advanceN), .sleep(sleep), .outEnN(outEnN), .addrIn(addrIn),
  .rdData(rdData), .rdPar(rdPar), .rdValid(rdValid), .curAddr(curAddr), .ctlStrobe(ctlStrobe)
);

// File: tb/sync_burst_ram_tb_top.sv
module sync_burst_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic procStrobeN = 1, ctrlStrobeN = 1, advanceN = 1, writeEnN = 1;
  logic orderSel = 0, sleep = 0, outEnN = 1;
  logic [AW-1:0] addrIn = '0;
  logic [15:0] wrData = '0;
  logic [1:0] wrPar = '0;
  logic [15:0] rdData;
  logic [1:0] rdPar;
  logic rdValid;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] expData [DEPTH];
  logic [1:0]  expPar  [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_ram dut_i (
    .clk(clk), .rst_n(rst_n), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .writeEnN(writeEnN), .orderSel(orderSel), .sleep(sleep),
    .outEnN(outEnN), .addrIn(addrIn), .wrData(wrData), .wrPar(wrPar),
    .rdData(rdData), .rdPar(rdPar), .rdValid(rdValid)
  );

  function automatic logic [15:0] patData(int a, int salt);
    return 16'((a * 16'h01d3 + 16'h002b + salt * 16'h0f11) & 16'hffff);
  endfunction
  function automatic logic [1:0] patPar(int a, int salt);
    return 2'((a + salt) & 3) ^ 2'b01;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1; writeEnN = 1; sleep = 0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkRead(string tag, int a);
    check(tag, {rdValid, rdPar, rdData}, {1'b1, expPar[a], expData[a]});
  endtask

  task automatic loadAddr(bit useProc, int a);
    addrIn = AW'(a);
    if (useProc) procStrobeN = 0; else ctrlStrobeN = 0;
    tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R9: released at reset with output enable high
    check("R9 reset release", {rdValid, rdPar, rdData}, '0);

    // R1: write with no strobe goes to address 0
    outEnN = 0;
    writeEnN = 0; wrData = 16'hbeef; wrPar = 2'b10; tick(); idle();
    expData[0] = 16'hbeef; expPar[0] = 2'b10;
    checkRead("R1 write after reset at addr 0", 0);

    // R2/R10: preload every location via controller strobe writes
    for (int a = 0; a < DEPTH; a++) begin
      addrIn = AW'(a); ctrlStrobeN = 0; writeEnN = 0;
      wrData = patData(a, 0); wrPar = patPar(a, 0);
      tick(); idle();
      expData[a] = patData(a, 0); expPar[a] = patPar(a, 0);
      checkRead("R2 R10 strobe write and read", a);
    end

    // R4/R5/R6: sweep both orders, all starts
    for (int ord = 0; ord < 2; ord++) begin
      orderSel = ord[0];
      for (int up = 0; up < 16; up += 5) begin
        for (int st = 0; st < 4; st++) begin
          loadAddr(up[0], up * 4 + st);
          checkRead(ord ? "R5 beat0" : "R4 beat0", up * 4 + st);
          for (int b = 1; b < 4; b++) begin
            int lowExp;
            lowExp = ord ? (st ^ b) : ((st + b) % 4);
            advanceN = 0; tick(); idle();
            checkRead(ord ? "R5 interleaved beat" : "R4 linear beat", up * 4 + lowExp);
            if (b == 1) begin
              tick();
              checkRead("R6 hold without advance", up * 4 + lowExp);
            end
          end
        end
      end
    end
    orderSel = 0;

    // R3: processor strobe suppresses write, alone and with controller strobe
    addrIn = 7; procStrobeN = 0; ctrlStrobeN = 0; writeEnN = 0; wrData = 16'h1234; wrPar = 2'b11;
    tick(); idle();
    checkRead("R3 both strobes no write", 7);
    addrIn = 9; procStrobeN = 0; writeEnN = 0; wrData = 16'h4321; wrPar = 2'b00;
    tick(); idle();
    checkRead("R3 proc strobe no write", 9);

    // R7: write at current burst address, advance after write
    loadAddr(0, 8);
    writeEnN = 0; advanceN = 0; wrData = 16'h5a5a; wrPar = 2'b01; tick(); idle();
    expData[8] = 16'h5a5a; expPar[8] = 2'b01;
    checkRead("R7 advanced to next beat", 9);
    loadAddr(1, 8);
    checkRead("R7 written at pre-advance address", 8);

    // R8: sleep ignores everything, releases outputs, keeps contents
    loadAddr(0, 33);
    sleep = 1; ctrlStrobeN = 0; addrIn = 20; writeEnN = 0; advanceN = 0;
    wrData = 16'hdead; wrPar = 2'b11;
    #1;
    check("R8 released in sleep", {rdValid, rdPar, rdData}, '0);
    tick(); tick();
    check("R8 released in sleep after edges", {30'b0, rdValid}, 0);
    idle();
    #1;
    checkRead("R8 address kept through sleep", 33);
    loadAddr(0, 20);
    checkRead("R8 array kept through sleep", 20);

    // R9: output enable high releases data and parity
    outEnN = 1; #1;
    check("R9 release with output enable high", {rdValid, rdPar, rdData}, '0);
    outEnN = 0; #1;
    checkRead("R9 driven again", 20);

    // R11: strobe beats advance on same edge
    orderSel = 1;
    addrIn = 46; ctrlStrobeN = 0; advanceN = 0; tick(); idle();
    checkRead("R11 strobe wins over advance", 46);
    advanceN = 0; tick(); idle();
    checkRead("R11 first beat after restart", 47);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule